// File: doc/BRIEF.md
# Indexed Interrupt Redirection Router

This block routes a set of interrupt input pins to interrupt messages aimed at processors. Software reaches it through a small window of two 32-bit locations. It first writes a register number into the index location. It then reads or writes the selected register through the data location. Behind that window sits a routing table that holds one 64-bit entry per input pin. Each entry is split into a low word and a high word, and the two words sit at consecutive register numbers.

The fields of each entry control how its pin behaves. One field masks the pin. Two fields choose edge or level triggering and the active polarity. The remaining fields are the vector, the delivery mode, the destination mode and the destination ID, and these are copied into the outgoing message. When an unmasked pin has a request, the block presents a message on a valid/ready output. If several pins request at once, the lowest-numbered pin goes first.

The bus side uses single-cycle write strobes and read strobes. Read data is registered and appears in the cycle after the read strobe. It stays there until the next read.

Top module: `irq_router`

## Requirements
- R1: Byte offset 0x00 is the index location: a write there stores wdata[7:0] as the index, and a read returns the index zero-extended. Byte offset 0x10 is the data location and accesses the register that the index selects. Writes to any other offset change nothing, and reads from any other offset return 0.
- R2: The low word of entry n is register 0x10+2n and the high word is register 0x11+2n. A word written through the data location reads back unchanged, including the words of the last entry (0x3E and 0x3F with 24 pins).
- R3: After reset, every low word reads 0x0001_0000 (mask set, all else 0), every high word reads 0, the index is 0 and msg_valid is 0.
- R4: Low-word bit 16 is the mask. While it is 1 the pin produces no message. An edge that arrives while the pin is masked is dropped, so clearing the mask later does not send that edge.
- R5: A message carries low bits 7:0 as msg_vector, low bits 10:8 as msg_dlv_mode, low bit 11 as msg_dst_mode, and high bits 27:24 (entry bits 59:56) as msg_dst_id.
- R6: With low-word bit 15 = 0 (edge mode), each transition of the pin into its active level produces exactly one message. Holding the pin active produces no further message.
- R7: Low-word bit 13 = 1 makes the pin active low. Bit 13 = 0 makes it active high.
- R8: With bit 15 = 1 (level mode), the pin requests for as long as it is active. A new message follows each completed handshake while the pin stays active, and none follows once the pin is inactive.
- R9: When several unmasked pins request at the same time, the message for the lowest-numbered pin is presented first.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and all message fields hold their values. A handshake clears the pending edge of the pin that was sent.
- R11: Register numbers outside 0x10 to 0x10+2*NUM_PINS-1 read as 0 through the data location, and writes to them change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; bus_rdata updates on the next cycle |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_PINS | Interrupt input pins |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_dst_mode | output | 1 | Destination mode (0 = physical) |
| msg_dst_id | output | 4 | Destination processor ID |

## Verification
Corrupted table state shows up on the bus in the cycle after a data-location read. It also shows up in the fields of the next message, which leaves the block two cycles after an edge reaches a pin. A stuck pending flag appears as an extra message within two cycles of a handshake. A lost pending flag appears as a message that never arrives. A wrong arbitration order shows as the wrong vector on the first message of a simultaneous pair. All of these are visible without looking inside the block.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 8;
  localparam int VEC_W    = 8;
  localparam int DLV_W    = 3;
  localparam int DST_W    = 4;

  // low-word field positions
  localparam int VEC_LSB  = 0;
  localparam int DLV_LSB  = 8;
  localparam int DMODE_B  = 11;
  localparam int POL_B    = 13;
  localparam int TRIG_B   = 15;
  localparam int MASK_B   = 16;
  // high-word field position (entry bits 59:56)
  localparam int DST_LSB  = 24;

  localparam logic [IDX_W-1:0]  TBL_BASE = 8'h10;
  localparam logic [WORD_W-1:0] LO_RESET = 32'h1 << MASK_B;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    logic [DLV_W-1:0] dlv;
    logic             dmode;
    logic [DST_W-1:0] dst;
  } msg_t;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 5,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output msg_t [NUM_PINS-1:0]     route,
  output logic [NUM_PINS-1:0]     trig_lvl,
  output logic [NUM_PINS-1:0]     pol_low,
  output logic [NUM_PINS-1:0]     mask
);
  localparam logic [ADDR_W-1:0] OFS_INDEX = '0;
  localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(16);
  localparam logic [IDX_W:0]    TBL_END   = (IDX_W+1)'(int'(TBL_BASE) + 2*NUM_PINS);

  logic [WORD_W-1:0] lo_mem [NUM_PINS];
  logic [WORD_W-1:0] hi_mem [NUM_PINS];
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  off;
  logic [PIN_W-1:0]  ent;
  logic              hit;

  always_comb begin
    off = idx_q - TBL_BASE;
    ent = PIN_W'(off >> 1);
    hit = (idx_q >= TBL_BASE) && ({1'b0, idx_q} < TBL_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        lo_mem[i] <= LO_RESET;
        hi_mem[i] <= '0;
      end
    end else if (bus_wr) begin
      if (bus_addr == OFS_INDEX) begin
        idx_q <= bus_wdata[IDX_W-1:0];
      end else if (bus_addr == OFS_DATA && hit) begin
        if (idx_q[0]) hi_mem[ent] <= bus_wdata;
        else          lo_mem[ent] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == OFS_INDEX)             bus_rdata <= WORD_W'(idx_q);
      else if (bus_addr == OFS_DATA && hit)  bus_rdata <= idx_q[0] ? hi_mem[ent] : lo_mem[ent];
      else                                   bus_rdata <= '0;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fields
    assign route[g].vector = lo_mem[g][VEC_LSB +: VEC_W];
    assign route[g].dlv    = lo_mem[g][DLV_LSB +: DLV_W];
    assign route[g].dmode  = lo_mem[g][DMODE_B];
    assign route[g].dst    = hi_mem[g][DST_LSB +: DST_W];
    assign trig_lvl[g]     = lo_mem[g][TRIG_B];
    assign pol_low[g]      = lo_mem[g][POL_B];
    assign mask[g]         = lo_mem[g][MASK_B];
  end
endmodule

// File: rtl/irq_router_pins.sv
module irq_router_pins #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] pol_low,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] eligible
);
  logic [NUM_PINS-1:0] active, prev_q, pend_q, rise;

  always_comb begin
    active   = irq_in ^ pol_low;
    rise     = active & ~prev_q;
    eligible = ~mask & ((trig_lvl & active) | (~trig_lvl & pend_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= active;
      pend_q <= (pend_q & ~clr) | (rise & ~mask & ~trig_lvl);
    end
  end
endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] eligible,
  input  msg_t [NUM_PINS-1:0] route,
  input  logic                msg_ready,
  output logic                msg_valid,
  output msg_t                msg,
  output logic [PIN_W-1:0]    sel_pin,
  output logic [NUM_PINS-1:0] clr
);
  logic [PIN_W-1:0] pick;
  logic             any;

  always_comb begin
    pick = '0;
    any  = |eligible;
    for (int i = NUM_PINS-1; i >= 0; i--) begin
      if (eligible[i]) pick = PIN_W'(i);
    end
    clr = '0;
    if (msg_valid && msg_ready) clr[sel_pin] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg       <= '0;
      sel_pin   <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any) begin
      msg_valid <= 1'b1;
      msg       <= route[pick];
      sel_pin   <= pick;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 5,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dlv_mode,
  output logic                msg_dst_mode,
  output logic [3:0]          msg_dst_id
);
  msg_t [NUM_PINS-1:0] route;
  logic [NUM_PINS-1:0] trig_lvl, pol_low, mask, eligible, clr;
  logic [PIN_W-1:0]    sel_pin;
  msg_t                msg;

  irq_router_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .route(route),
    .trig_lvl(trig_lvl), .pol_low(pol_low), .mask(mask)
  );

  irq_router_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig_lvl(trig_lvl), .pol_low(pol_low),
    .mask(mask), .clr(clr), .eligible(eligible)
  );

  irq_router_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .eligible(eligible), .route(route), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg(msg), .sel_pin(sel_pin), .clr(clr)
  );

  assign msg_vector   = msg.vector;
  assign msg_dlv_mode = msg.dlv;
  assign msg_dst_mode = msg.dmode;
  assign msg_dst_id   = msg.dst;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [2:0]          msg_dlv_mode,
  input logic                msg_dst_mode,
  input logic [3:0]          msg_dst_id,
  input logic [NUM_PINS-1:0] eligible,
  input logic [NUM_PINS-1:0] mask,
  input logic [PIN_W-1:0]    sel_pin
);
  logic [NUM_PINS-1:0] elig_q, mask_q, below;

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_q <= '0;
      mask_q <= '1;
    end else begin
      elig_q <= eligible;
      mask_q <= mask;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) below[i] = (PIN_W'(i) < sel_pin);
  end

  assert_reset_quiet_R3: assert property (@(posedge clk) rst |=> !msg_valid);

  assert_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> !mask_q[sel_pin]);

  assert_lowest_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (elig_q[sel_pin] && ((elig_q & below) == '0)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dlv_mode)
                                   && $stable(msg_dst_mode) && $stable(msg_dst_id)));
endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dlv_mode(msg_dlv_mode), .msg_dst_mode(msg_dst_mode),
  .msg_dst_id(msg_dst_id), .eligible(eligible), .mask(mask), .sel_pin(sel_pin)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_dlv_mode;
  logic        msg_dst_mode;
  logic [3:0]  msg_dst_id;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_router #(.NUM_PINS(N)) i_irq_router (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv_mode(msg_dlv_mode), .msg_dst_mode(msg_dst_mode), .msg_dst_id(msg_dst_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_write(5'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_read(5'h10, d);
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic ack();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic quiet(input string req, input int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(req, {31'h0, seen}, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R3 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
    bus_read(5'h00, d);            chk("R3 index after reset", d, 32'h0);
    reg_read(8'h10, d);            chk("R3 entry0 low", d, 32'h0001_0000);
    reg_read(8'h11, d);            chk("R3 entry0 high", d, 32'h0);
    reg_read(8'h3E, d);            chk("R3 entry23 low", d, 32'h0001_0000);
  endtask

  task automatic t_window();
    logic [31:0] d;
    bus_write(5'h00, 32'h0000_0013);
    bus_read(5'h00, d);            chk("R1 index readback", d, 32'h13);
    bus_write(5'h04, 32'h0000_0012);
    bus_read(5'h00, d);            chk("R1 write to other offset ignored", d, 32'h13);
    bus_read(5'h08, d);            chk("R1 read of other offset", d, 32'h0);
  endtask

  task automatic t_table();
    logic [31:0] d;
    reg_write(8'h12, 32'h1234_00AB);
    reg_read(8'h12, d);            chk("R2 entry1 low", d, 32'h1234_00AB);
    reg_write(8'h13, 32'hF500_0000);
    reg_read(8'h13, d);            chk("R2 entry1 high", d, 32'hF500_0000);
    reg_write(8'h3E, 32'h0001_A0FF);
    reg_write(8'h3F, 32'h0C00_0001);
    reg_read(8'h3E, d);            chk("R2 entry23 low", d, 32'h0001_A0FF);
    reg_read(8'h3F, d);            chk("R2 entry23 high", d, 32'h0C00_0001);
  endtask

  task automatic t_undefined();
    logic [31:0] d;
    reg_write(8'h05, 32'hFFFF_FFFF);
    reg_read(8'h05, d);            chk("R11 undefined low index reads 0", d, 32'h0);
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_write(8'h41, 32'hFFFF_FFFF);
    reg_read(8'h40, d);            chk("R11 index past table reads 0", d, 32'h0);
    reg_read(8'h3F, d);            chk("R11 entry23 high untouched", d, 32'h0C00_0001);
    reg_read(8'h10, d);            chk("R11 entry0 low untouched", d, 32'h0001_0000);
  endtask

  task automatic t_mask();
    reg_write(8'h18, 32'h0001_0044);     // pin 4, masked, edge
    @(negedge clk); irq_in[4] = 1'b1;
    quiet("R4 masked pin sends nothing", 10);
    reg_write(8'h18, 32'h0000_0044);     // unmask while held high
    quiet("R4 edge seen while masked is dropped", 10);
    @(negedge clk); irq_in[4] = 1'b0;
  endtask

  task automatic t_edge_fields();
    bit got;
    reg_write(8'h15, 32'h0A00_0000);     // pin 2 dest 0xA
    reg_write(8'h14, 32'h0000_0942);     // vec 0x42, dlv 1, dmode 1, edge
    @(negedge clk); irq_in[2] = 1'b1;
    wait_msg(got);
    chk("R6 edge produces message", {31'h0, got}, 32'h1);
    chk("R5 vector", {24'h0, msg_vector}, 32'h42);
    chk("R5 delivery mode", {29'h0, msg_dlv_mode}, 32'h1);
    chk("R5 destination mode", {31'h0, msg_dst_mode}, 32'h1);
    chk("R5 destination id", {28'h0, msg_dst_id}, 32'hA);
    ack();
    quiet("R6 held level gives no second message", 10);
    @(negedge clk); irq_in[2] = 1'b0;
    @(negedge clk); irq_in[2] = 1'b1;
    wait_msg(got);
    chk("R6 second edge produces message", {24'h0, got ? msg_vector : 8'h0}, 32'h42);
    ack();
    @(negedge clk); irq_in[2] = 1'b0;
    quiet("R10 handshake cleared pending", 6);
  endtask

  task automatic t_polarity();
    bit got;
    @(negedge clk); irq_in[6] = 1'b1;   // idle for active low
    reg_write(8'h1C, 32'h0000_2066);
    quiet("R7 high input idle when active low", 6);
    @(negedge clk); irq_in[6] = 1'b0;
    wait_msg(got);
    chk("R7 falling input triggers active-low pin", {24'h0, got ? msg_vector : 8'h0}, 32'h66);
    ack();
    @(negedge clk); irq_in[6] = 1'b1;
    quiet("R7 return to high is not an edge", 6);
  endtask

  task automatic t_level();
    bit got;
    reg_write(8'h20, 32'h0000_8088);     // pin 8 level, active high
    @(negedge clk); irq_in[8] = 1'b1;
    wait_msg(got);
    chk("R8 level message", {24'h0, got ? msg_vector : 8'h0}, 32'h88);
    ack();
    wait_msg(got);
    chk("R8 level resend while active", {24'h0, got ? msg_vector : 8'h0}, 32'h88);
    @(negedge clk); irq_in[8] = 1'b0;
    ack();
    quiet("R8 no message once inactive", 10);
  endtask

  task automatic t_priority();
    bit got;
    reg_write(8'h16, 32'h0000_0033);     // pin 3
    reg_write(8'h1A, 32'h0000_0055);     // pin 5
    @(negedge clk); irq_in[5] = 1'b1; irq_in[3] = 1'b1;
    wait_msg(got);
    chk("R9 lowest pin first", {24'h0, got ? msg_vector : 8'h0}, 32'h33);
    repeat (5) @(negedge clk);
    chk("R10 valid held under backpressure", {31'h0, msg_valid}, 32'h1);
    chk("R10 vector held under backpressure", {24'h0, msg_vector}, 32'h33);
    ack();
    wait_msg(got);
    chk("R9 next pin follows", {24'h0, got ? msg_vector : 8'h0}, 32'h55);
    ack();
    @(negedge clk); irq_in[5] = 1'b0; irq_in[3] = 1'b0;
    quiet("R10 both pending cleared", 6);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_table();
    t_undefined();
    t_mask();
    t_edge_fields();
    t_polarity();
    t_level();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule